// File: doc/BRIEF.md
# Strobe-Driven FIFO with Clear-Time Threshold Register

This block is a first-in first-out word buffer, 9 bits wide by default. Producers and consumers drive it with active-low strobes, one for writing and one for reading. A single system clock samples both strobes and acts on their edges. A write starts when its strobe falls and stores the input word when the strobe rises. A read starts when its strobe falls, shows the oldest word one clock later and advances past that word when the strobe rises. Three active-low flags report the fill state: full, empty and a programmable occupancy flag.

An active-low clear input rewinds both pointers and empties the buffer. While clear is held low, the strobes have a second meaning. A write pulse loads the occupancy threshold from the data inputs, and a read pulse puts the stored threshold on the data outputs. A clear with no strobe pulses leaves the threshold as it was. A synchronous active-high power-up reset puts the block in a disarmed state, and writes stay blocked until the first clear.

Top module: `strobe_fifo`

## Requirements
- R1: After `rst`, `empty_n`=0, `full_n`=1, `half_n`=1 and `dout`=0, and every write pulse is ignored until `clr_n` has been sampled low at least once.
- R2: When `clr_n` is sampled low, the occupancy becomes zero and both pointers return to the first location, so the next word read is the first word written after the clear. During and after the clear, `empty_n`=0, `full_n`=1 and `half_n`=1.
- R3: A write-strobe pulse that rises while `clr_n` is low loads the threshold register from `din`.
- R4: A read-strobe pulse that falls while `clr_n` is low switches `dout` to the threshold value one clock later. `dout` keeps showing the threshold until the next accepted read.
- R5: A clear without strobe pulses leaves the threshold unchanged and does not change `dout`.
- R6: A write is accepted only if `full_n` is high when its strobe falls. The word is taken from `din` at the clock that sees the strobe rise. Accepted words come out in the order they were written, including when a read runs at the same time.
- R7: A write strobe that falls while `full_n` is low is ignored. The stored words and the flags stay unchanged.
- R8: A read strobe that falls while `empty_n` is high shows the oldest word on `dout` one clock later. The occupancy drops at the clock that sees the strobe rise. A read strobe that falls while `empty_n` is low leaves `dout` and the flags unchanged.
- R9: `full_n` is low exactly when the occupancy equals DEPTH, and `empty_n` is low exactly when the occupancy is zero. Both flags update at the same clock edge that changes the occupancy.
- R10: `half_n` is low when the threshold is nonzero and the occupancy is at least the threshold. Otherwise it is high, and it is always high when the threshold is zero.
- R11: A read and a write that complete at the same clock leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both strobes |
| rst | input | 1 | Synchronous active-high power-up reset |
| clr_n | input | 1 | Active-low clear; while low, the strobes access the threshold |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| din | input | DW | Write data, or the threshold value during clear |
| dout | output | DW | Read data, or the threshold value after a read pulse during clear |
| full_n | output | 1 | Low when the buffer holds DEPTH words |
| empty_n | output | 1 | Low when the buffer holds no words |
| half_n | output | 1 | Low when the occupancy is at least a nonzero threshold |

## Verification
The bench goes after these corner cases:
- A write issued before the first clear. A design that forgets the disarmed state would raise `empty_n`.
- A write while the buffer is full. A design that accepts it would overwrite the oldest word, and the scoreboard would see that word wrong.
- A read while the buffer is empty. A design that accepts it would change `dout`.
- A read and a write that complete in the same clock. A design that miscounts here would leave `empty_n` in the wrong state after the remaining reads.
- A threshold loaded during clear, then read back through a read pulse, then checked to be unchanged after a clear with no strobes.
- A threshold of zero. A design that compares without the zero guard would pull `half_n` low at once.
- Pointer wraparound, and rewinding a full buffer with a clear. A design that gets either wrong would return stale words.

// File: rtl/strobe_fifo_pkg.sv
`timescale 1ns/1ps
package strobe_fifo_pkg;
  // Edge events derived from one sampled active-low strobe
  typedef struct packed {
    logic fall;
    logic rise;
  } strb_ev_t;
endpackage

// File: rtl/strobe_edge.sv
`timescale 1ns/1ps
module strobe_edge
  import strobe_fifo_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     strb_n,
  output strb_ev_t ev
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= strb_n;
  end

  assign ev.fall = prev_q & ~strb_n;
  assign ev.rise = ~prev_q & strb_n;
endmodule

// File: rtl/fifo_ram.sv
`timescale 1ns/1ps
module fifo_ram #(
  parameter int DW    = 9,
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // simple dual port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fifo_ctrl.sv
`timescale 1ns/1ps
module fifo_ctrl
  import strobe_fifo_pkg::*;
#(
  parameter int DW    = 9,
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int CW    = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_n,
  input  strb_ev_t      wr_ev,
  input  strb_ev_t      rd_ev,
  input  logic [DW-1:0] din,
  output logic          ram_we,
  output logic          ram_re,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [DW-1:0] thr,
  output logic          show_thr,
  output logic          full_n,
  output logic          empty_n,
  output logic          half_n
);
  localparam int TW = (CW > DW) ? CW : DW;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic          armed, wr_act, rd_act;
  logic          wr_go, rd_go, wr_done, rd_done;
  logic [CW-1:0] cnt, cnt_nxt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_go   = clr_n & armed & wr_ev.fall & full_n;
  assign rd_go   = clr_n & rd_ev.fall & empty_n;
  assign wr_done = clr_n & wr_act & wr_ev.rise;
  assign rd_done = clr_n & rd_act & rd_ev.rise;
  assign ram_we  = wr_done;
  assign ram_re  = rd_go;

  always_comb begin
    cnt_nxt = cnt;
    case ({wr_done, rd_done})
      2'b10:   cnt_nxt = cnt + ONE;
      2'b01:   cnt_nxt = cnt - ONE;
      default: cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      wr_act   <= 1'b0;
      rd_act   <= 1'b0;
      cnt      <= '0;
      waddr    <= '0;
      raddr    <= '0;
      thr      <= '0;
      show_thr <= 1'b1;
      full_n   <= 1'b1;
      empty_n  <= 1'b0;
      half_n   <= 1'b1;
    end else if (!clr_n) begin
      armed   <= 1'b1;
      wr_act  <= 1'b0;
      rd_act  <= 1'b0;
      cnt     <= '0;
      waddr   <= '0;
      raddr   <= '0;
      full_n  <= 1'b1;
      empty_n <= 1'b0;
      half_n  <= 1'b1;
      if (wr_ev.rise) thr      <= din;   // threshold load
      if (rd_ev.fall) show_thr <= 1'b1;  // threshold readback
    end else begin
      if (wr_go)        wr_act <= 1'b1;
      else if (wr_done) wr_act <= 1'b0;
      if (rd_go)        rd_act <= 1'b1;
      else if (rd_done) rd_act <= 1'b0;
      if (rd_go)   show_thr <= 1'b0;
      if (wr_done) waddr    <= bump(waddr);
      if (rd_done) raddr    <= bump(raddr);
      cnt     <= cnt_nxt;
      full_n  <= (cnt_nxt != FULL_CNT);
      empty_n <= (cnt_nxt != '0);
      half_n  <= (thr == '0) || (TW'(cnt_nxt) < TW'(thr));
    end
  end

  // R9: occupancy never exceeds the depth
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT);
  // R9: full and empty are never active together
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!full_n && !empty_n));
  // R2: a sampled clear leaves the flags in their cleared state
  a_r2_clear_flags: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (!empty_n && full_n && half_n && cnt == '0));
  // R7: a write strobe while full never opens a write cycle
  a_r7_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !full_n && wr_ev.fall) |=> !wr_act);
  // R11: outside clear the occupancy moves by at most one per clock
  a_r11_single_step: assert property (@(posedge clk) disable iff (rst)
    $past(clr_n) |-> (cnt == $past(cnt) || cnt == $past(cnt) + ONE || cnt + ONE == $past(cnt)));
  // R1: before the first clear the buffer stays empty
  a_r1_disarmed_empty: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !empty_n);
  // R10: a zero threshold keeps the occupancy flag inactive
  a_r10_zero_thr: assert property (@(posedge clk) disable iff (rst)
    (thr == '0) |-> half_n);
endmodule

// File: rtl/strobe_fifo.sv
`timescale 1ns/1ps
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int DW    = 9,
  parameter int DEPTH = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          full_n,
  output logic          empty_n,
  output logic          half_n
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  strb_ev_t      wr_ev, rd_ev;
  logic          ram_we, ram_re, show_thr;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] thr, ram_q;

  strobe_edge u_wr_edge (.clk(clk), .rst(rst), .strb_n(wr_n), .ev(wr_ev));
  strobe_edge u_rd_edge (.clk(clk), .rst(rst), .strb_n(rd_n), .ev(rd_ev));

  fifo_ctrl #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .clr_n(clr_n), .wr_ev(wr_ev), .rd_ev(rd_ev), .din(din),
    .ram_we(ram_we), .ram_re(ram_re), .waddr(waddr), .raddr(raddr), .thr(thr),
    .show_thr(show_thr), .full_n(full_n), .empty_n(empty_n), .half_n(half_n)
  );

  fifo_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(waddr), .wdata(din),
    .re(ram_re), .raddr(raddr), .rdata(ram_q)
  );

  // both sources are registers; the select picks threshold or stored word
  assign dout = show_thr ? thr : ram_q;
endmodule

// File: tb/strobe_fifo_bench.sv
`timescale 1ns/1ps
module strobe_fifo_bench;
  localparam int DW = 9;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst = 1'b1, clr_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic full_n, empty_n, half_n;

  int n_chk = 0, n_bad = 0, cnt_m = 0;
  bit armed_m = 1'b0, mon_arm = 1'b0;
  logic [DW-1:0] exp_q[$];

  always #5 clk = ~clk;

  strobe_fifo #(.DW(DW), .DEPTH(DEPTH)) u_strobe_fifo (
    .clk(clk), .rst(rst), .clr_n(clr_n), .wr_n(wr_n), .rd_n(rd_n), .din(din),
    .dout(dout), .full_n(full_n), .empty_n(empty_n), .half_n(half_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // monitor: compares the word shown one clock after an accepted read strobe
  always @(negedge clk) begin
    if (mon_arm) begin
      mon_arm = 1'b0;
      if (exp_q.size() == 0) chk("R6 R8 scoreboard underrun", 1, 0);
      else chk("R2 R6 R8 read order", int'(dout), int'(exp_q.pop_front()));
    end
  end

  task automatic wr_pulse(input logic [DW-1:0] d);
    bit take;
    @(negedge clk);
    din = d; wr_n = 1'b0;
    take = armed_m && (cnt_m < DEPTH);
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    if (take) begin exp_q.push_back(d); cnt_m++; end
  endtask

  task automatic rd_pulse();
    bit take;
    @(negedge clk);
    rd_n = 1'b0;
    take = (cnt_m > 0);
    @(posedge clk);
    if (take) mon_arm = 1'b1;
    @(negedge clk);
    rd_n = 1'b1;
    if (take) cnt_m--;
    @(negedge clk);
  endtask

  task automatic clr_pulse(input bit do_wr, input bit do_rd, input logic [DW-1:0] d);
    @(negedge clk);
    clr_n = 1'b0;
    if (do_wr) begin din = d; wr_n = 1'b0; end
    if (do_rd) rd_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    clr_n = 1'b1;
    @(negedge clk);
    cnt_m = 0; exp_q.delete(); armed_m = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty_n after rst", empty_n, 0);
    chk("R1 full_n after rst", full_n, 1);
    chk("R1 half_n after rst", half_n, 1);
    chk("R1 dout after rst", dout, 0);
    wr_pulse(9'h055);
    chk("R1 write before first clear ignored", empty_n, 0);

    clr_pulse(0, 0, '0);
    chk("R2 empty_n after clear", empty_n, 0);
    chk("R2 full_n after clear", full_n, 1);
    chk("R2 half_n after clear", half_n, 1);

    clr_pulse(1, 0, 9'd3);
    chk("R3 threshold loaded", dout, 3);
    clr_pulse(0, 1, '0);
    chk("R4 threshold readback", dout, 3);

    // fill to full, threshold 3
    wr_pulse(9'h101);
    chk("R9 empty_n after first write", empty_n, 1);
    chk("R10 half_n at count 1", half_n, 1);
    wr_pulse(9'h0A2);
    chk("R10 half_n at count 2", half_n, 1);
    wr_pulse(9'h1FF);
    chk("R10 half_n at count 3", half_n, 0);
    wr_pulse(9'h033);
    chk("R9 full_n at depth", full_n, 0);
    wr_pulse(9'h0EE);
    chk("R7 full_n after write while full", full_n, 0);
    chk("R7 empty_n after write while full", empty_n, 1);

    rd_pulse();
    chk("R9 full_n after one read", full_n, 1);
    chk("R10 half_n at count 3 after read", half_n, 0);
    rd_pulse();
    chk("R10 half_n at count 2 after read", half_n, 1);
    rd_pulse();
    rd_pulse();
    chk("R9 empty_n when drained", empty_n, 0);
    rd_pulse();
    chk("R8 dout after read while empty", dout, 9'h033);
    chk("R8 empty_n after read while empty", empty_n, 0);

    clr_pulse(0, 0, '0);
    chk("R5 dout unchanged by plain clear", dout, 9'h033);
    clr_pulse(0, 1, '0);
    chk("R5 threshold kept by plain clear", dout, 3);

    // R11 read and write completing together
    wr_pulse(9'h011);
    wr_pulse(9'h022);
    @(negedge clk);
    din = 9'h144; wr_n = 1'b0; rd_n = 1'b0;
    @(posedge clk);
    mon_arm = 1'b1;
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    exp_q.push_back(9'h144);
    chk("R11 empty_n after joint op", empty_n, 1);
    chk("R11 full_n after joint op", full_n, 1);
    rd_pulse();
    chk("R11 empty_n with one left", empty_n, 1);
    rd_pulse();
    chk("R11 empty_n after two reads", empty_n, 0);

    // R10 zero threshold
    clr_pulse(1, 0, '0);
    for (int i = 1; i <= DEPTH; i++) begin
      wr_pulse(DW'(i));
      chk("R10 half_n with zero threshold", half_n, 1);
    end
    chk("R9 full_n with zero threshold", full_n, 0);

    // R2 clear rewinds a full buffer
    clr_pulse(0, 0, '0);
    chk("R2 empty_n after clearing full buffer", empty_n, 0);
    chk("R2 full_n after clearing full buffer", full_n, 1);
    wr_pulse(9'h1A5);
    rd_pulse();
    chk("R2 empty_n after rewind read", empty_n, 0);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule